// File: doc/BRIEF.md
# Interrupt Mode and Refresh Control Unit

This block holds the interrupt-acceptance state of an 8-bit processor core: the interrupt mode, the two interrupt enable flags, the vector base register and the memory refresh counter. The instruction decoder drives it with one-cycle strobes: enable, disable, mode select, return from interrupt, load base and load refresh. The fetch unit reports each completed opcode fetch and each instruction boundary. At a boundary the block decides whether a pending non-maskable or maskable request is taken.

When a request is taken, the block produces the address that the core jumps to or reads its vector from. A non-maskable request always goes to 0066h. A maskable request is vectored according to the current mode:

- **Device mode:** the byte driven by the device is run as an instruction.
- **Fixed mode:** the target is 0038h.
- **Table mode:** the table address combines the base register with the device byte.

Stack pushes and memory reads are done elsewhere in the core. This block only produces the addresses.

Top module: `irq_mode_ctrl`

## Requirements
- R1: After synchronous active-low reset, both enable flags, the mode (0), the base register, the refresh counter and all pulse outputs are 0.
- R2: A mode write with code 0, 1 or 2 sets the mode to that value one cycle later. Code 3 is ignored and the previous mode is kept.
- R3: In mode 1, a taken maskable request gives target address 0038h.
- R4: In mode 2, a taken maskable request gives a target address with the base register as the high byte and the device byte as the low byte.
- R5: In mode 0, a taken maskable request raises `exec_dev_o` and copies the device byte to `opcode_o`. If the byte has the restart form (bits 7:6 = 11, bits 2:0 = 111), the target is 00h followed by bits 5:3 times 8. Otherwise the target is 0000h.
- R6: The enable strobe sets both flags and the disable strobe clears both. A maskable request is taken only when flag 1 is set.
- R7: After an enable strobe, the first instruction boundary never takes a maskable request. The boundary after that one can.
- R8: Each fetch-done pulse increments bits 6:0 of the refresh counter, wrapping 7Fh to 00h, and leaves bit 7 unchanged. A refresh load writes the accumulator byte instead.
- R9: The return strobe copies flag 2 into flag 1.
- R10: A rising edge on `nmi_req_i` makes a non-maskable request pending. At the next boundary it is taken ahead of any maskable request, with target 0066h and no acknowledge. It clears flag 1 and keeps flag 2.
- R11: A maskable request is sampled only at instruction boundaries. In the accepting cycle `ack_o` pulses. Acceptance clears both flags, and `take_o` is high in the following cycle.
- R12: The base load strobe copies the accumulator byte into the vector base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_en_i | input | 1 | Enable-interrupts strobe |
| clr_en_i | input | 1 | Disable-interrupts strobe |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_sel_i | input | 2 | Mode code for a mode write |
| ret_irq_i | input | 1 | Return from interrupt (either kind) strobe |
| base_wr_i | input | 1 | Load vector base from accumulator |
| rfsh_wr_i | input | 1 | Load refresh counter from accumulator |
| acc_i | input | 8 | Accumulator byte for loads |
| fetch_done_i | input | 1 | Opcode fetch completed |
| insn_end_i | input | 1 | Instruction boundary |
| irq_req_i | input | 1 | Maskable request (level) |
| nmi_req_i | input | 1 | Non-maskable request (edge) |
| dev_byte_i | input | 8 | Byte from interrupting device |
| ack_o | output | 1 | Acknowledge, maskable accept cycle |
| take_o | output | 1 | Interrupt taken pulse |
| nmi_taken_o | output | 1 | Taken interrupt was non-maskable |
| exec_dev_o | output | 1 | Core must execute `opcode_o` |
| opcode_o | output | 8 | Device-supplied instruction byte |
| tgt_addr_o | output | 16 | Target or table address |
| mode_o | output | 2 | Current interrupt mode |
| iff1_o | output | 1 | Enable flag 1 |
| iff2_o | output | 1 | Enable flag 2 |
| base_o | output | 8 | Vector base register |
| rfsh_o | output | 8 | Refresh counter |

## Verification
Acceptance is tried in each mode with several device bytes:

- **Table mode:** two different base/byte pairs show that both halves of the address are used.
- **Device mode:** a restart byte and a non-restart byte tell the restart decode apart from plain passthrough.

Requests outside a boundary, requests with the flags cleared, and a request at the boundary right after an enable separate the boundary sampling, flag gating and shadow. A non-maskable request raised together with a maskable one shows the priority and the asymmetric flag update. A following return shows flag 2 being restored into flag 1.

// File: rtl/irq_pkg.sv
// Package: shared types and fixed vectors of the interrupt control unit.
// Assumes an 8-bit data path and a 16-bit address space.
package irq_pkg;
    typedef enum logic [1:0] {
        MODE_DEV   = 2'd0,
        MODE_FIXED = 2'd1,
        MODE_TABLE = 2'd2
    } irq_mode_e;

    localparam logic [15:0] FIXED_VEC = 16'h0038;
    localparam logic [15:0] NMI_VEC   = 16'h0066;
endpackage

// File: rtl/iff_ctrl.sv
// Module: the two interrupt enable flags and the one-boundary shadow after enable.
// Assumes the enable strobe arrives before the boundary that ends the enabling
// instruction. Priority per cycle: acceptance, then disable, then enable, then return.
module iff_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic ret_irq,
    input  logic take_mask,
    input  logic take_nmi,
    input  logic insn_end,
    output logic iff1,
    output logic iff2,
    output logic shadow
);
    // Update the enable flag pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_mask) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_nmi) begin
            iff1 <= 1'b0;
        end else if (clr_en) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (set_en) begin
            iff1 <= 1'b1;
            iff2 <= 1'b1;
        end else if (ret_irq) begin
            iff1 <= iff2;
        end
    end

    // Hold off maskable acceptance through the boundary that follows an enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        shadow <= 1'b0;
        else if (set_en)   shadow <= 1'b1;
        else if (insn_end) shadow <= 1'b0;
    end
endmodule

// File: rtl/refresh_ctr.sv
// Module: refresh counter; the low bits count fetches and wrap, the top bit holds.
// Assumes a load and a fetch in the same cycle resolve in favour of the load.
module refresh_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fetch,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] cnt
);
    localparam int LOW_W = W - 1;

    // Count fetches in the low field; load overrides.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= din;
        else if (fetch) cnt <= {cnt[W-1], cnt[LOW_W-1:0] + {{(LOW_W-1){1'b0}}, 1'b1}};
    end
endmodule

// File: rtl/vec_gen.sv
// Module: combinational target address for a taken interrupt.
// Assumes the device byte is valid in the accepting cycle.
module vec_gen
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [1:0]          mode,
    input  logic                is_nmi,
    input  logic [DATA_W-1:0]   base,
    input  logic [DATA_W-1:0]   dev,
    output logic [2*DATA_W-1:0] addr,
    output logic                run_dev
);
    localparam int ADDR_W = 2 * DATA_W;

    logic is_rst;
    assign is_rst = (dev[7:6] == 2'b11) && (dev[2:0] == 3'b111);

    // Select the address by request kind and mode.
    always_comb begin
        addr    = '0;
        run_dev = 1'b0;
        if (is_nmi) begin
            addr = NMI_VEC[ADDR_W-1:0];
        end else begin
            case (mode)
                MODE_FIXED: addr = FIXED_VEC[ADDR_W-1:0];
                MODE_TABLE: addr = {base, dev};
                default: begin
                    run_dev = 1'b1;
                    if (is_rst) addr = {{(ADDR_W-6){1'b0}}, dev[5:3], 3'b000};
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_mode_ctrl.sv
// Module: interrupt acceptance and refresh control for an 8-bit core.
// Decides at instruction boundaries whether a request is taken and registers the
// resulting target. Assumes decoder strobes are one cycle wide.
module irq_mode_ctrl
    import irq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic              mode_wr_i,
    input  logic [1:0]        mode_sel_i,
    input  logic              ret_irq_i,
    input  logic              base_wr_i,
    input  logic              rfsh_wr_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              fetch_done_i,
    input  logic              insn_end_i,
    input  logic              irq_req_i,
    input  logic              nmi_req_i,
    input  logic [DATA_W-1:0] dev_byte_i,
    output logic              ack_o,
    output logic              take_o,
    output logic              nmi_taken_o,
    output logic              exec_dev_o,
    output logic [DATA_W-1:0] opcode_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [1:0]        mode_o,
    output logic              iff1_o,
    output logic              iff2_o,
    output logic [DATA_W-1:0] base_o,
    output logic [DATA_W-1:0] rfsh_o
);
    logic              shadow;
    logic              nmi_q, nmi_pend, nmi_go, irq_go;
    logic [ADDR_W-1:0] vec_addr;
    logic              vec_dev;

    assign nmi_go = insn_end_i && nmi_pend;
    assign irq_go = insn_end_i && irq_req_i && iff1_o && !shadow && !nmi_pend;
    assign ack_o  = irq_go;

    // Mode register; the reserved code leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n)                               mode_o <= MODE_DEV;
        else if (mode_wr_i && mode_sel_i != 2'd3) mode_o <= mode_sel_i;
    end

    // Vector base register.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_o <= '0;
        else if (base_wr_i) base_o <= acc_i;
    end

    // Edge-detect the non-maskable request and hold it until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi_req_i;
            nmi_pend <= (nmi_pend && !nmi_go) || (nmi_req_i && !nmi_q);
        end
    end

    // Register the acceptance result and its target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o      <= 1'b0;
            nmi_taken_o <= 1'b0;
            exec_dev_o  <= 1'b0;
            opcode_o    <= '0;
            tgt_addr_o  <= '0;
        end else begin
            take_o      <= nmi_go || irq_go;
            nmi_taken_o <= nmi_go;
            exec_dev_o  <= irq_go && vec_dev;
            if (nmi_go || irq_go) tgt_addr_o <= vec_addr;
            if (irq_go && vec_dev) opcode_o <= dev_byte_i;
        end
    end

    iff_ctrl u_iff (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_en_i),
        .clr_en    (clr_en_i),
        .ret_irq   (ret_irq_i),
        .take_mask (irq_go),
        .take_nmi  (nmi_go),
        .insn_end  (insn_end_i),
        .iff1      (iff1_o),
        .iff2      (iff2_o),
        .shadow    (shadow)
    );

    refresh_ctr #(.W(DATA_W)) u_rfsh (
        .clk   (clk),
        .rst_n (rst_n),
        .fetch (fetch_done_i),
        .load  (rfsh_wr_i),
        .din   (acc_i),
        .cnt   (rfsh_o)
    );

    vec_gen #(.DATA_W(DATA_W)) u_vec (
        .mode    (mode_o),
        .is_nmi  (nmi_pend),
        .base    (base_o),
        .dev     (dev_byte_i),
        .addr    (vec_addr),
        .run_dev (vec_dev)
    );
endmodule

// File: rtl/irq_mode_ctrl_chk.sv
// Checker: temporal properties of the interrupt control unit, bound to its top.
module irq_mode_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              set_en_i,
    input logic              clr_en_i,
    input logic              ret_irq_i,
    input logic              rfsh_wr_i,
    input logic              fetch_done_i,
    input logic              insn_end_i,
    input logic              irq_req_i,
    input logic              ack_o,
    input logic              take_o,
    input logic              nmi_taken_o,
    input logic [2*DATA_W-1:0] tgt_addr_o,
    input logic [1:0]        mode_o,
    input logic              iff1_o,
    input logic              iff2_o,
    input logic [DATA_W-1:0] rfsh_o
);
    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    assert_refresh_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done_i && !rfsh_wr_i) |=>
            (rfsh_o[DATA_W-2:0] == $past(rfsh_o[DATA_W-2:0]) + 1'b1) &&
            (rfsh_o[DATA_W-1] == $past(rfsh_o[DATA_W-1])));

    assert_fixed_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !nmi_taken_o && $past(mode_o) == 2'd1) |-> tgt_addr_o == 16'h0038);

    assert_nmi_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_taken_o |-> (tgt_addr_o == 16'h0066 && !iff1_o));

    assert_mask_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !nmi_taken_o) |-> (!iff1_o && !iff2_o));

    assert_ack_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (iff1_o && irq_req_i && insn_end_i));

    assert_ret_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_irq_i && !set_en_i && !clr_en_i && !insn_end_i) |=> iff1_o == $past(iff2_o));
endmodule

bind irq_mode_ctrl irq_mode_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_en_i     (set_en_i),
    .clr_en_i     (clr_en_i),
    .ret_irq_i    (ret_irq_i),
    .rfsh_wr_i    (rfsh_wr_i),
    .fetch_done_i (fetch_done_i),
    .insn_end_i   (insn_end_i),
    .irq_req_i    (irq_req_i),
    .ack_o        (ack_o),
    .take_o       (take_o),
    .nmi_taken_o  (nmi_taken_o),
    .tgt_addr_o   (tgt_addr_o),
    .mode_o       (mode_o),
    .iff1_o       (iff1_o),
    .iff2_o       (iff2_o),
    .rfsh_o       (rfsh_o)
);

// File: tb/tb_irq_mode_ctrl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_irq_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic set_en_i, clr_en_i, mode_wr_i, ret_irq_i, base_wr_i, rfsh_wr_i;
    logic [1:0] mode_sel_i;
    logic [7:0] acc_i, dev_byte_i;
    logic fetch_done_i, insn_end_i, irq_req_i, nmi_req_i;
    logic ack_o, take_o, nmi_taken_o, exec_dev_o, iff1_o, iff2_o;
    logic [7:0] opcode_o, base_o, rfsh_o;
    logic [15:0] tgt_addr_o;
    logic [1:0] mode_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_mode_ctrl dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock edge, then settle 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        set_en_i = 0; clr_en_i = 0; mode_wr_i = 0; ret_irq_i = 0; base_wr_i = 0;
        rfsh_wr_i = 0; fetch_done_i = 0; insn_end_i = 0; irq_req_i = 0;
        mode_sel_i = 0; acc_i = 0; dev_byte_i = 0;
    endtask

    task automatic pulse_en();
        set_en_i = 1; tick(); set_en_i = 0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_wr_i = 1; mode_sel_i = m; tick(); mode_wr_i = 0;
    endtask

    // Boundary with optional maskable request; returns ack seen before the edge.
    task automatic boundary(input logic irq, input logic [7:0] dev, output logic ack);
        insn_end_i = 1; irq_req_i = irq; dev_byte_i = dev;
        #0.5 ack = ack_o;
        tick();
        insn_end_i = 0; irq_req_i = 0;
    endtask

    // Enable, then clear the shadow with one empty boundary.
    task automatic arm();
        logic a;
        pulse_en();
        boundary(1'b0, 8'h00, a);
    endtask

    task automatic t_reset();
        rst_n = 0; nmi_req_i = 0; idle();
        tick(); tick();
        rst_n = 1;
        tick();
        chk("R1 iff1", iff1_o, 0);
        chk("R1 iff2", iff2_o, 0);
        chk("R1 mode", mode_o, 0);
        chk("R1 base", base_o, 0);
        chk("R1 rfsh", rfsh_o, 0);
        chk("R1 take", take_o, 0);
    endtask

    task automatic t_modes();
        set_mode(2'd2); chk("R2 mode2", mode_o, 2);
        set_mode(2'd3); chk("R2 reserved ignored", mode_o, 2);
        set_mode(2'd1); chk("R2 mode1", mode_o, 1);
        set_mode(2'd0); chk("R2 mode0", mode_o, 0);
    endtask

    task automatic t_base();
        base_wr_i = 1; acc_i = 8'h5A; tick(); base_wr_i = 0;
        chk("R12 base", base_o, 8'h5A);
    endtask

    task automatic t_gating();
        logic a;
        clr_en_i = 1; tick(); clr_en_i = 0;
        chk("R6 DI iff1", iff1_o, 0);
        boundary(1'b1, 8'h00, a);
        chk("R6 no ack when disabled", a, 0);
        chk("R6 no take when disabled", take_o, 0);
        arm();
        chk("R6 EI iff1", iff1_o, 1);
        chk("R6 EI iff2", iff2_o, 1);
        irq_req_i = 1; tick(); irq_req_i = 0;
        chk("R11 no take off boundary", take_o, 0);
        chk("R11 flags kept off boundary", iff1_o, 1);
    endtask

    task automatic t_shadow();
        logic a;
        set_mode(2'd1);
        pulse_en();
        boundary(1'b1, 8'h00, a);
        chk("R7 shadow blocks", take_o, 0);
        boundary(1'b1, 8'h00, a);
        chk("R11 ack", a, 1);
        chk("R7 taken after shadow", take_o, 1);
        chk("R3 fixed vector", tgt_addr_o, 16'h0038);
        chk("R11 iff1 cleared", iff1_o, 0);
        chk("R11 iff2 cleared", iff2_o, 0);
        tick();
        chk("R11 take is a pulse", take_o, 0);
    endtask

    task automatic t_table();
        logic a;
        set_mode(2'd2);
        arm(); boundary(1'b1, 8'hC4, a);
        chk("R4 table addr 1", tgt_addr_o, 16'h5AC4);
        base_wr_i = 1; acc_i = 8'h81; tick(); base_wr_i = 0;
        arm(); boundary(1'b1, 8'h02, a);
        chk("R4 table addr 2", tgt_addr_o, 16'h8102);
        chk("R4 no exec", exec_dev_o, 0);
    endtask

    task automatic t_dev();
        logic a;
        set_mode(2'd0);
        arm(); boundary(1'b1, 8'hEF, a);
        chk("R5 exec", exec_dev_o, 1);
        chk("R5 opcode", opcode_o, 8'hEF);
        chk("R5 restart target", tgt_addr_o, 16'h0028);
        arm(); boundary(1'b1, 8'h3E, a);
        chk("R5 opcode plain", opcode_o, 8'h3E);
        chk("R5 plain target", tgt_addr_o, 16'h0000);
    endtask

    task automatic t_nmi();
        logic a;
        set_mode(2'd1);
        arm();
        nmi_req_i = 1; tick();
        boundary(1'b1, 8'h00, a);
        chk("R10 no ack for nmi", a, 0);
        chk("R10 taken", take_o, 1);
        chk("R10 nmi flag", nmi_taken_o, 1);
        chk("R10 target", tgt_addr_o, 16'h0066);
        chk("R10 iff1 cleared", iff1_o, 0);
        chk("R10 iff2 kept", iff2_o, 1);
        boundary(1'b0, 8'h00, a);
        chk("R10 level does not retrigger", take_o, 0);
        nmi_req_i = 0;
        ret_irq_i = 1; tick(); ret_irq_i = 0;
        chk("R9 return restores iff1", iff1_o, 1);
        clr_en_i = 1; tick(); clr_en_i = 0;
        ret_irq_i = 1; tick(); ret_irq_i = 0;
        chk("R9 return copies cleared iff2", iff1_o, 0);
    endtask

    task automatic t_refresh();
        rfsh_wr_i = 1; acc_i = 8'hFE; tick(); rfsh_wr_i = 0;
        chk("R8 load", rfsh_o, 8'hFE);
        fetch_done_i = 1; tick();
        chk("R8 inc", rfsh_o, 8'hFF);
        tick();
        chk("R8 wrap keeps bit7", rfsh_o, 8'h80);
        fetch_done_i = 0;
        rfsh_wr_i = 1; acc_i = 8'h7F; tick(); rfsh_wr_i = 0;
        fetch_done_i = 1; tick(); fetch_done_i = 0;
        chk("R8 wrap low", rfsh_o, 8'h00);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_modes();
        t_base();
        t_gating();
        t_shadow();
        t_table();
        t_dev();
        t_nmi();
        t_refresh();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule